// File: doc/BRIEF.md
# I2C Bus Idle and Clock-Low Timeout Monitor

This block watches the two lines of an I2C bus, already synchronised to the system clock, and counts prescaled ticks to find two fault conditions. The first is a stalled transfer: the bus is marked busy, but SCL has been high with no activity on either line for too long. The second is a clock line held low by some device for too long. Each condition has its own timeout length, chosen from a short coded table, and each is reported as a one-cycle flag that the surrounding controller turns into an interrupt.

The idle-timeout flag can also drive a force-idle pulse. When the go-idle option is set, the bus-state tracker uses this pulse to mark the bus free, so that a new transfer may start after a stuck one. When the option is clear, the timeout is reported but the bus state is left alone. All pins are plain control and status signals. No data flows through the block, so there is no handshake.

Top module: `i2c_timeout_monitor`

## Requirements
- R1: While reset is held and on the first cycle after release, `idle_to`, `low_to` and `force_idle` are all 0.
- R2: `idle_sel` codes 1, 2 and 3 give idle limits of 40, 80 and 160 ticks. `idle_to` goes high for one cycle, on the cycle after the clock edge that samples the tick completing the limit.
- R3: The idle count advances only on cycles where SCL is high, `bus_busy` is high, and neither SCL nor SDA differs from its value on the previous cycle. On any other cycle the count returns to zero.
- R4: `idle_sel` code 0 disables the idle check, so `idle_to` never fires.
- R5: `low_sel` codes 1 to 5 give clock-low limits of 40, 80, 160, 320 and 1024 ticks, with the same pulse timing as R2.
- R6: The clock-low count advances only while SCL is low and restarts from zero whenever SCL is high, so each rising edge of SCL restarts it.
- R7: `low_sel` codes 0, 6 and 7 disable the clock-low check.
- R8: Each expiry gives exactly one pulse. A flag does not fire again until its count has been returned to zero.
- R9: `force_idle` pulses in the same cycle as `idle_to` when `go_idle_en` is 1. When `go_idle_en` is 0, `force_idle` stays 0.
- R10: The counts advance only on cycles where `tick` is high. Cycles without a tick neither advance nor clear them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Prescaled timebase strobe, one cycle wide |
| scl_in | input | 1 | Synchronised SCL level |
| sda_in | input | 1 | Synchronised SDA level |
| bus_busy | input | 1 | Bus is currently marked busy |
| idle_sel | input | 2 | Idle timeout code (0 off, 1..3 = 40/80/160 ticks) |
| low_sel | input | 3 | Clock-low timeout code (0 off, 1..5 = 40/80/160/320/1024, 6..7 off) |
| go_idle_en | input | 1 | Let an idle timeout force the bus idle |
| idle_to | output | 1 | One-cycle bus-idle timeout flag |
| low_to | output | 1 | One-cycle clock-low timeout flag |
| force_idle | output | 1 | One-cycle request to mark the bus idle |

## Verification
Directed holds of a steady SCL level, one for every select code, measure the tick count up to the first pulse and show that only one pulse comes per expiry. This separates correct limits from off-by-one or wrongly decoded ones. SDA toggles, short SCL highs inside a low stretch, reserved codes and a tick on every other cycle each test one clearing or gating rule on its own. Several thousand random cycles, with rare line edges, busy changes and select changes, are checked cycle by cycle against a bench model. These show how the clearing rules interact when several happen together.

// File: rtl/i2c_tmo_pkg.sv
package i2c_tmo_pkg;
  // Timebase table shared by the monitor and its checker
  localparam int unsigned TMO_BASE_TICKS = 40;
  localparam int unsigned TMO_LONG_TICKS = 1024;
  localparam int unsigned TMO_CNT_W      = $clog2(TMO_LONG_TICKS + 1);

  typedef enum logic [1:0] {
    IDLE_OFF = 2'd0,
    IDLE_X1  = 2'd1,
    IDLE_X2  = 2'd2,
    IDLE_X4  = 2'd3
  } idle_code_e;
endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_edge,
  output logic sda_edge
);
  logic scl_q, sda_q;

  // Idle bus level is high, so reset the history to 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_in;
      sda_q <= sda_in;
    end
  end

  assign scl_edge = scl_in ^ scl_q;
  assign sda_edge = sda_in ^ sda_q;
endmodule

// File: rtl/i2c_tmo_limits.sv
module i2c_tmo_limits #(
  parameter int unsigned BASE_TICKS = 40,
  parameter int unsigned LONG_TICKS = 1024,
  parameter int unsigned CNT_W      = 11
) (
  input  logic [1:0]       idle_sel,
  input  logic [2:0]       low_sel,
  output logic [CNT_W-1:0] idle_limit,
  output logic [CNT_W-1:0] low_limit
);
  localparam logic [CNT_W-1:0] L1 = CNT_W'(BASE_TICKS);
  localparam logic [CNT_W-1:0] L2 = CNT_W'(BASE_TICKS * 2);
  localparam logic [CNT_W-1:0] L4 = CNT_W'(BASE_TICKS * 4);
  localparam logic [CNT_W-1:0] L8 = CNT_W'(BASE_TICKS * 8);
  localparam logic [CNT_W-1:0] LL = CNT_W'(LONG_TICKS);

  // A zero limit means the check is switched off
  always_comb begin
    unique case (idle_sel)
      2'd1:    idle_limit = L1;
      2'd2:    idle_limit = L2;
      2'd3:    idle_limit = L4;
      default: idle_limit = '0;
    endcase
  end

  always_comb begin
    case (low_sel)
      3'd1:    low_limit = L1;
      3'd2:    low_limit = L2;
      3'd3:    low_limit = L4;
      3'd4:    low_limit = L8;
      3'd5:    low_limit = LL;
      default: low_limit = '0;   // 0, 6, 7 are off
    endcase
  end
endmodule

// File: rtl/i2c_tmo_counter.sv
module i2c_tmo_counter #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;
  logic             armed;
  logic             hit;

  assign armed = run && (limit != '0);
  assign hit   = armed && tick && (cnt == limit - 1'b1);

  // Saturates at the limit so a pulse needs a clear before the next one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      expire <= 1'b0;
    end else begin
      expire <= hit;
      if (!armed)
        cnt <= '0;
      else if (tick && (cnt < limit))
        cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_timeout_monitor.sv
module i2c_timeout_monitor
  import i2c_tmo_pkg::*;
#(
  parameter int unsigned BASE_TICKS = TMO_BASE_TICKS,
  parameter int unsigned LONG_TICKS = TMO_LONG_TICKS
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       bus_busy,
  input  logic [1:0] idle_sel,
  input  logic [2:0] low_sel,
  input  logic       go_idle_en,
  output logic       idle_to,
  output logic       low_to,
  output logic       force_idle
);
  localparam int unsigned MAXT  = (LONG_TICKS > BASE_TICKS * 8) ? LONG_TICKS : BASE_TICKS * 8;
  localparam int unsigned CNT_W = $clog2(MAXT + 1);
  localparam int unsigned NCH   = 2;   // channel 0 idle, channel 1 clock-low

  logic             scl_edge, sda_edge;
  logic [CNT_W-1:0] idle_limit, low_limit;
  logic [NCH-1:0]   ch_run, ch_exp;
  logic [CNT_W-1:0] ch_limit [NCH];
  logic             force_q;

  i2c_line_sampler u_lines (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_edge(scl_edge), .sda_edge(sda_edge)
  );

  i2c_tmo_limits #(.BASE_TICKS(BASE_TICKS), .LONG_TICKS(LONG_TICKS), .CNT_W(CNT_W)) u_lim (
    .idle_sel(idle_sel), .low_sel(low_sel),
    .idle_limit(idle_limit), .low_limit(low_limit)
  );

  // Idle: SCL high with bus busy and no line activity; low: SCL low
  assign ch_run[0]   = scl_in && bus_busy && !scl_edge && !sda_edge;
  assign ch_run[1]   = !scl_in;
  assign ch_limit[0] = idle_limit;
  assign ch_limit[1] = low_limit;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    i2c_tmo_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .run(ch_run[g]),
      .limit(ch_limit[g]), .expire(ch_exp[g])
    );
  end

  // Registered alongside the idle expiry so both pulses coincide
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      force_q <= 1'b0;
    else
      force_q <= go_idle_en && tick && ch_run[0] && (idle_limit != '0) &&
                 (ch_limit[0] != '0) && g_ch[0].u_cnt.hit;
  end

  assign idle_to    = ch_exp[0];
  assign low_to     = ch_exp[1];
  assign force_idle = force_q;
endmodule

// File: rtl/i2c_tmo_checker.sv
module i2c_tmo_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       scl_in,
  input logic       bus_busy,
  input logic [1:0] idle_sel,
  input logic [2:0] low_sel,
  input logic       go_idle_en,
  input logic       idle_to,
  input logic       low_to,
  input logic       force_idle
);
  a_r8_idle_single: assert property (@(posedge clk) disable iff (!rst_n)
    idle_to |=> !idle_to);
  a_r8_low_single: assert property (@(posedge clk) disable iff (!rst_n)
    low_to |=> !low_to);
  a_r9_force_with_idle: assert property (@(posedge clk) disable iff (!rst_n)
    force_idle |-> idle_to);
  a_r9_force_follows_en: assert property (@(posedge clk) disable iff (!rst_n)
    idle_to |-> (force_idle == $past(go_idle_en)));
  a_r4_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
    idle_to |-> ($past(idle_sel) != 2'd0));
  a_r7_low_off: assert property (@(posedge clk) disable iff (!rst_n)
    low_to |-> ($past(low_sel) != 3'd0 && $past(low_sel) < 3'd6));
  a_r10_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_to || low_to) |-> $past(tick));
  a_r3_idle_cond: assert property (@(posedge clk) disable iff (!rst_n)
    idle_to |-> $past(scl_in && bus_busy));
  a_r6_low_cond: assert property (@(posedge clk) disable iff (!rst_n)
    low_to |-> $past(!scl_in));
endmodule

bind i2c_timeout_monitor i2c_tmo_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .scl_in(scl_in), .bus_busy(bus_busy),
  .idle_sel(idle_sel), .low_sel(low_sel), .go_idle_en(go_idle_en),
  .idle_to(idle_to), .low_to(low_to), .force_idle(force_idle)
);

// File: tb/i2c_timeout_monitor_bench.sv
`timescale 1ns/1ps
module i2c_timeout_monitor_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, scl = 1'b1, sda = 1'b1, busy = 1'b0, go = 1'b0;
  logic [1:0] isel = 2'd0;
  logic [2:0] lsel = 3'd0;
  logic idle_to, low_to, force_idle;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // bench model state
  int  m_icnt = 0, m_lcnt = 0;
  bit  m_pscl = 1, m_psda = 1;
  bit  e_idle = 0, e_low = 0, e_force = 0;
  bit  o_idle, o_low, o_force;

  always #10 clk = ~clk;

  i2c_timeout_monitor u_i2c_timeout_monitor (
    .clk(clk), .rst_n(rst_n), .tick(tick), .scl_in(scl), .sda_in(sda),
    .bus_busy(busy), .idle_sel(isel), .low_sel(lsel), .go_idle_en(go),
    .idle_to(idle_to), .low_to(low_to), .force_idle(force_idle)
  );

  function automatic int idle_thr(input logic [1:0] c);
    case (c) 2'd1: return 40; 2'd2: return 80; 2'd3: return 160; default: return 0; endcase
  endfunction

  function automatic int low_thr(input logic [2:0] c);
    case (c)
      3'd1: return 40; 3'd2: return 80; 3'd3: return 160;
      3'd4: return 320; 3'd5: return 1024; default: return 0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: compare, drive new inputs, advance model
  task automatic step(input bit t, input bit s, input bit d, input bit b);
    int il, ll;
    bit irun, lrun;
    @(negedge clk);
    o_idle = idle_to; o_low = low_to; o_force = force_idle;
    check(o_idle == e_idle, "R2/R3 idle_to", o_idle, e_idle);
    check(o_low == e_low, "R5/R6 low_to", o_low, e_low);
    check(o_force == e_force, "R9 force_idle", o_force, e_force);
    tick = t; scl = s; sda = d; busy = b;
    il = idle_thr(isel); ll = low_thr(lsel);
    irun = (il != 0) && s && b && (s == m_pscl) && (d == m_psda);
    lrun = (ll != 0) && !s;
    e_idle  = irun && t && (m_icnt == il - 1);
    e_force = e_idle && go;
    e_low   = lrun && t && (m_lcnt == ll - 1);
    if (!irun) m_icnt = 0; else if (t && m_icnt < il) m_icnt++;
    if (!lrun) m_lcnt = 0; else if (t && m_lcnt < ll) m_lcnt++;
    m_pscl = s; m_psda = d;
  endtask

  // Hold a pattern; report first pulse index and pulse count
  task automatic hold_idle(input int n, output int first, output int cnt, output int fcnt);
    first = -1; cnt = 0; fcnt = 0;
    step(1, 1, 1, 0);                       // clear count with bus not busy
    for (int i = 0; i < n; i++) begin
      step(1, 1, 1, 1);
      if (i > 0 && o_idle) begin cnt++; if (first < 0) first = i; end
      if (i > 0 && o_force) fcnt++;
    end
  endtask

  task automatic hold_low(input int n, output int first, output int cnt);
    first = -1; cnt = 0;
    step(1, 1, 1, 0);
    for (int i = 0; i < n; i++) begin
      step(1, 0, 1, 0);
      if (i > 0 && o_low) begin cnt++; if (first < 0) first = i; end
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int first, cnt, fcnt;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(idle_to == 0 && low_to == 0 && force_idle == 0, "R1 outputs in reset",
          {idle_to, low_to, force_idle}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(idle_to == 0 && low_to == 0 && force_idle == 0, "R1 outputs after reset",
          {idle_to, low_to, force_idle}, 0);

    // R2, R8, R9: idle limits with go-idle on
    go = 1;
    for (int c = 1; c <= 3; c++) begin
      isel = 2'(c); lsel = 0;
      hold_idle(2 * idle_thr(isel) + 10, first, cnt, fcnt);
      check(first == idle_thr(isel), "R2 idle limit", first, idle_thr(isel));
      check(cnt == 1, "R8 idle single pulse", cnt, 1);
      check(fcnt == 1, "R9 force with go-idle", fcnt, 1);
    end
    // R9: go-idle off
    go = 0; isel = 2'd1;
    hold_idle(60, first, cnt, fcnt);
    check(cnt == 1 && fcnt == 0, "R9 no force when disabled", fcnt, 0);
    // R4: idle code 0
    isel = 2'd0;
    hold_idle(400, first, cnt, fcnt);
    check(cnt == 0, "R4 idle check off", cnt, 0);
    // R3: SDA activity keeps clearing
    isel = 2'd1; cnt = 0;
    step(1, 1, 1, 0);
    for (int i = 0; i < 300; i++) begin
      step(1, 1, ((i / 30) % 2) == 0, 1);
      if (o_idle) cnt++;
    end
    check(cnt == 0, "R3 sda edges clear idle", cnt, 0);
    isel = 2'd0;

    // R5: clock-low limits
    for (int c = 1; c <= 5; c++) begin
      lsel = 3'(c);
      hold_low(low_thr(lsel) + 40, first, cnt);
      check(first == low_thr(lsel), "R5 low limit", first, low_thr(lsel));
      check(cnt == 1, "R8 low single pulse", cnt, 1);
    end
    // R7: reserved and off codes
    for (int c = 0; c <= 7; c += 1) begin
      if (c != 0 && c != 6 && c != 7) continue;
      lsel = 3'(c);
      hold_low(1100, first, cnt);
      check(cnt == 0, "R7 low check off", cnt, 0);
    end
    // R6: short high restarts the count
    lsel = 3'd1; cnt = 0;
    for (int r = 0; r < 4; r++) begin
      step(1, 1, 1, 0);
      for (int i = 0; i < 35; i++) begin step(1, 0, 1, 0); if (o_low) cnt++; end
    end
    check(cnt == 0, "R6 rising scl restarts low count", cnt, 0);
    // R10: tick on every other cycle
    lsel = 3'd0; isel = 2'd1; go = 1;
    first = -1;
    step(1, 1, 1, 0);
    for (int i = 0; i < 120; i++) begin
      step((i % 2) == 0, 1, 1, 1);
      if (o_idle && first < 0) first = i;
    end
    check(first == 79, "R10 counts only on tick", first, 79);

    // Random mix checked cycle by cycle against the model
    begin
      bit s = 1, d = 1, b = 1;
      for (int i = 0; i < 20000; i++) begin
        if (i % 2000 == 0) begin
          isel = 2'($urandom_range(0, 3));
          lsel = 3'($urandom_range(0, 7));
          go   = 1'($urandom_range(0, 1));
        end
        if ($urandom_range(0, 119) == 0) s = ~s;
        if ($urandom_range(0, 89) == 0) d = ~d;
        if ($urandom_range(0, 499) == 0) b = ~b;
        step($urandom_range(0, 3) != 0, s, d, b);
      end
    end
    step(0, 1, 1, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule